// File: doc/BRIEF.md
# Page-Buffered Byte Write Sequencer

This block is a clock-synchronous model of the write path of a byte-wide nonvolatile memory. It samples three active-low strobes (select, read enable and write enable), an address bus and a data bus. Each qualified write puts one byte into a page buffer. The page is chosen by the upper address bits and the byte within the page by the low bits. Further bytes may follow, provided each new write begins inside a load window counted from the start of the previous one. When the window closes with no new write, the block enters a self-timed programming phase. In that phase it copies every loaded byte into its internal array and leaves all other bytes of the page untouched.

While programming runs, the block does not read the array. A read instead returns a status byte built from the last loaded data: bit 7 is inverted and bit 6 flips on every new read. A host can therefore poll for completion by data compare or by toggle detection. Both timing windows are counted in clock cycles, so a simulation can use short values.

Top module: `nvm_page_wseq`

## Requirements
- R1: After synchronous reset, `busy`, `page_err` and `dout_en` are 0.
- R2: A write is accepted only while `sel_n`=0, `wen_n`=0 and `ren_n`=1 are sampled together. If `ren_n` is low or `sel_n` is high, the pulse starts no page load and leaves the array unchanged.
- R3: The address is taken in the first sampled cycle of a qualified write. The data is the last value sampled before the write qualification drops.
- R4: A page is 2^PAGE_W bytes (64 by default). Address bits [ADDR_W-1:PAGE_W] pick the page and bits [PAGE_W-1:0] pick the byte. All bytes loaded into one page are committed by a single programming phase.
- R5: A write that starts fewer than LOAD_GAP cycles after the previous write start extends the current load, and `busy` stays 0.
- R6: `busy` rises exactly LOAD_GAP+3 cycles after the write-enable fall of the last loaded byte, counted at the pins.
- R7: `busy` stays high for max(PROG_CYC, 2^PAGE_W+2) cycles, then falls.
- R8: A read while `busy` is high returns the last loaded byte with bit 7 inverted and bits 5..0 unchanged.
- R9: During `busy`, bit 6 of the status byte differs between successive reads. After `busy` falls, reads return array data.
- R10: `dout_en` is 1 only for reads (`sel_n`=0, `ren_n`=0), three cycles after the pins, and returns to 0 after the read ends.
- R11: A byte whose page bits differ from the first byte of the current load is dropped and sets `page_err`. The flag holds until the next load begins, and that new load clears it.
- R12: Writes issued while `busy` is high change no array byte and start no new load.
- R13: Bytes of the page that were not loaded keep their previous contents after programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Device select, active low |
| ren_n | input | 1 | Read/output enable, active low |
| wen_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Read data valid / output drive enable |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | An off-page byte was dropped during the current load |

## Verification
The bench builds the block with ADDR_W=10, a load window of 40 cycles and a programming time of 100 cycles. With these values a complete 64-byte page load, the exact cycle at which `busy` rises and its exact length can all be checked within a few thousand cycles. The short programming time still leaves room for several polling reads inside one busy window. This brings the toggle and the inverted-bit status reads, and writes arriving during programming, into reach.

// File: rtl/nvm_pw_pkg.sv
package nvm_pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } wphase_e;
endpackage

// File: rtl/nvm_pw_strobe.sv
// Samples the pins and derives write/read start and end events.
module nvm_pw_strobe #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ren_n,
  input  logic              wen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [7:0]        lat_data,
  output logic              wr_act,
  output logic              wr_start,
  output logic              wr_end,
  output logic              rd_act,
  output logic              rd_start
);
  logic       s_sel_n, s_ren_n, s_wen_n;
  logic [7:0] s_din;
  logic       wr_q, rd_q;

  assign wr_act   = ~s_sel_n & ~s_wen_n & s_ren_n;
  assign rd_act   = ~s_sel_n & ~s_ren_n;
  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign rd_start = rd_act & ~rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sel_n  <= 1'b1;
      s_ren_n  <= 1'b1;
      s_wen_n  <= 1'b1;
      smp_addr <= '0;
      s_din    <= '0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      s_sel_n  <= sel_n;
      s_ren_n  <= ren_n;
      s_wen_n  <= wen_n;
      smp_addr <= addr;
      s_din    <= din;
      wr_q     <= wr_act;
      rd_q     <= rd_act;
      if (wr_start) lat_addr <= smp_addr;
      if (wr_act)   lat_data <= s_din;
    end
  end

  // R3: address stays frozen for the rest of a write once taken
  a_r3_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (wr_act && wr_q && $past(wr_q)) |-> $stable(lat_addr));
endmodule

// File: rtl/nvm_pw_pagebuf.sv
// Page buffer with per-byte load mask, page tag and off-page error flag.
module nvm_pw_pagebuf #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_first,
  input  logic                     load_next,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [ADDR_W-PAGE_W-1:0] page,
  output logic [7:0]               rd_byte,
  output logic                     rd_mask,
  output logic                     page_err,
  output logic [7:0]               last_byte
);
  localparam int NBYTE = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [7:0]       pbuf_mem [NBYTE];
  logic [NBYTE-1:0] mask;
  logic [PAGE_W-1:0] ofs;
  logic [PG_W-1:0]   pg;
  logic              accept, drop;

  assign ofs    = wr_addr[PAGE_W-1:0];
  assign pg     = wr_addr[ADDR_W-1:PAGE_W];
  assign accept = load_first | (load_next & (pg == page));
  assign drop   = load_next & (pg != page);

  always_ff @(posedge clk) begin
    if (accept) pbuf_mem[ofs] <= wr_data;
    rd_byte <= pbuf_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask      <= '0;
      page      <= '0;
      page_err  <= 1'b0;
      last_byte <= '0;
      rd_mask   <= 1'b0;
    end else begin
      rd_mask <= mask[rd_idx];
      if (load_first) begin
        mask     <= NBYTE'(1) << ofs;
        page     <= pg;
        page_err <= 1'b0;
      end else if (accept) begin
        mask[ofs] <= 1'b1;
      end else if (drop) begin
        page_err <= 1'b1;
      end
      if (accept) last_byte <= wr_data;
    end
  end

  // R11: a dropped byte raises the flag
  a_r11_drop_flags: assert property (@(posedge clk) disable iff (rst)
    drop |=> page_err);
  // R11: flag only moves on a new load or a drop
  a_r11_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (!load_first && !drop) |=> $stable(page_err));
  // R13: a fresh load marks exactly one byte as loaded
  a_r13_fresh_mask: assert property (@(posedge clk) disable iff (rst)
    load_first |=> ($countones(mask) == 1));
endmodule

// File: rtl/nvm_pw_ctrl.sv
// Phase control: load window timer, programming timer, commit walk, toggle.
module nvm_pw_ctrl
  import nvm_pw_pkg::*;
#(
  parameter int LOAD_GAP = 400,
  parameter int PROG_LEN = 2000,
  parameter int PAGE_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_act,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              rd_start,
  output wphase_e           phase,
  output logic              load_first,
  output logic              load_next,
  output logic [PAGE_W-1:0] commit_idx,
  output logic              cm_vld,
  output logic [PAGE_W-1:0] cm_idx,
  output logic              tgl
);
  localparam int NBYTE = 1 << PAGE_W;
  localparam int GW    = $clog2(LOAD_GAP + 1);
  localparam int PCW   = $clog2(PROG_LEN + 1);
  localparam logic [GW-1:0]  GAP_LIM   = GW'(LOAD_GAP);
  localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_LEN - 1);
  localparam logic [PCW-1:0] CM_END    = PCW'(NBYTE);

  logic [GW-1:0]  gap_cnt;
  logic [PCW-1:0] prog_cnt;
  logic           commit_on;

  assign load_first = wr_end & (phase == ST_IDLE);
  assign load_next  = wr_end & (phase == ST_LOAD);
  assign commit_idx = prog_cnt[PAGE_W-1:0];
  assign commit_on  = (phase == ST_PROG) && (prog_cnt < CM_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= ST_IDLE;
      gap_cnt  <= '0;
      prog_cnt <= '0;
      cm_vld   <= 1'b0;
      cm_idx   <= '0;
      tgl      <= 1'b0;
    end else begin
      cm_vld <= commit_on;
      cm_idx <= commit_idx;
      if (wr_start && phase != ST_PROG) gap_cnt <= '0;
      else if (gap_cnt != GAP_LIM)      gap_cnt <= gap_cnt + 1'b1;
      if (rd_start && phase == ST_PROG) tgl <= ~tgl;
      case (phase)
        ST_IDLE: if (wr_end) phase <= ST_LOAD;
        ST_LOAD: if (gap_cnt == GAP_LIM && !wr_act) begin
          phase    <= ST_PROG;
          prog_cnt <= '0;
        end
        ST_PROG: if (prog_cnt == PROG_LAST) phase <= ST_IDLE;
                 else prog_cnt <= prog_cnt + 1'b1;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R6: programming is only entered from a load with no write in flight
  a_r6_prog_entry: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_PROG && $past(phase) != ST_PROG) |->
      ($past(phase) == ST_LOAD && !$past(wr_act)));
  // R5: a write in flight keeps the load open
  a_r5_hold_load: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_LOAD && wr_act) |=> phase == ST_LOAD);
  // R7: programming timer stays inside its length
  a_r7_prog_bounded: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_PROG) |-> (prog_cnt <= PROG_LAST));
  // R9: toggle bit frozen outside programming
  a_r9_tgl_frozen: assert property (@(posedge clk) disable iff (rst)
    (phase != ST_PROG) |=> $stable(tgl));
endmodule

// File: rtl/nvm_pw_array.sv
// Byte array (one write port, one synchronous read port) and output stage.
module nvm_pw_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_act,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        last_byte,
  input  logic              tgl,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] arr_q;
  logic       rd_q1;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    arr_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q1   <= 1'b0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      rd_q1   <= rd_act;
      dout_en <= rd_q1;
      if (!rd_q1)    dout <= '0;
      else if (busy) dout <= {~last_byte[7], tgl, last_byte[5:0]};
      else           dout <= arr_q;
    end
  end

  // R10: output valid only two cycles after a sampled read
  a_r10_en_from_read: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(rd_act, 2));
  // R12: the array is written only inside programming
  a_r12_commit_in_prog: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);
endmodule

// File: rtl/nvm_page_wseq.sv
module nvm_page_wseq
  import nvm_pw_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 6,
  parameter int LOAD_GAP = 400,
  parameter int PROG_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ren_n,
  input  logic              wen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PROG_LEN   = (PROG_CYC < PAGE_BYTES + 2) ? PAGE_BYTES + 2 : PROG_CYC;

  logic [ADDR_W-1:0]        smp_addr, lat_addr;
  logic [7:0]               lat_data, rd_byte, last_byte;
  logic                     wr_act, wr_start, wr_end, rd_act, rd_start;
  logic                     load_first, load_next, cm_vld, rd_mask, tgl;
  logic [PAGE_W-1:0]        commit_idx, cm_idx;
  logic [ADDR_W-PAGE_W-1:0] page;
  wphase_e                  phase;

  assign busy = (phase == ST_PROG);

  nvm_pw_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk, .rst, .sel_n, .ren_n, .wen_n, .addr, .din,
    .smp_addr, .lat_addr, .lat_data,
    .wr_act, .wr_start, .wr_end, .rd_act, .rd_start
  );

  nvm_pw_ctrl #(.LOAD_GAP(LOAD_GAP), .PROG_LEN(PROG_LEN), .PAGE_W(PAGE_W)) u_ctrl (
    .clk, .rst, .wr_act, .wr_start, .wr_end, .rd_start,
    .phase, .load_first, .load_next, .commit_idx, .cm_vld, .cm_idx, .tgl
  );

  nvm_pw_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_pbuf (
    .clk, .rst, .load_first, .load_next,
    .wr_addr(lat_addr), .wr_data(lat_data), .rd_idx(commit_idx),
    .page, .rd_byte, .rd_mask, .page_err, .last_byte
  );

  nvm_pw_array #(.ADDR_W(ADDR_W)) u_array (
    .clk, .rst, .rd_addr(smp_addr), .rd_act, .busy,
    .wr_en(cm_vld & rd_mask), .wr_addr({page, cm_idx}), .wr_data(rd_byte),
    .last_byte, .tgl, .dout, .dout_en
  );

  // R2: a write only starts from a qualified strobe combination at the pins
  a_r2_write_qualified: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(!sel_n && !wen_n && ren_n));
  // R8: status byte carries inverted bit 7 and true low bits
  a_r8_status_byte: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(busy)) |->
      ((dout[7] != $past(last_byte[7])) && (dout[5:0] == $past(last_byte[5:0]))));
endmodule

// File: tb/sim_nvm_page_wseq.sv
module sim_nvm_page_wseq;
  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam int GAP   = 40;
  localparam int PCYC  = 100;
  localparam int NV    = 8;
  // {address, write data, expected read-back}
  localparam logic [25:0] VEC [NV] = '{
    {10'h000, 8'hA5, 8'hA5}, {10'h03F, 8'h0F, 8'h0F},
    {10'h040, 8'hF0, 8'hF0}, {10'h181, 8'h5A, 8'h5A},
    {10'h2AA, 8'h55, 8'h55}, {10'h3FF, 8'hC3, 8'hC3},
    {10'h155, 8'h80, 8'h80}, {10'h07E, 8'h7E, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, ren_n = 1'b1, wen_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, busy, page_err;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  nvm_page_wseq #(.ADDR_W(AW), .PAGE_W(6), .LOAD_GAP(GAP), .PROG_CYC(PCYC)) u0 (
    .clk, .rst, .sel_n, .ren_n, .wen_n, .addr, .din,
    .dout, .dout_en, .busy, .page_err
  );

  function automatic logic [7:0] fillv(input int i);
    return 8'(i * 3 + 7);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; sel_n = 1'b0; wen_n = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b1; wen_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); addr = a; sel_n = 1'b0; ren_n = 1'b0;
    repeat (5) @(negedge clk);
    d = dout; en = dout_en;
    sel_n = 1'b1; ren_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_prog;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] d, r1, r2;
    logic en;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 page_err", {7'd0, page_err}, 8'd0);
    chk("R1 dout_en", {7'd0, dout_en}, 8'd0);

    // R4 table: single-byte loads across pages
    for (int i = 0; i < NV; i++) begin
      wr_byte(VEC[i][25:16], VEC[i][15:8]);
      wait_prog();
      rd_byte(VEC[i][25:16], d, en);
      chk("R4 table readback", d, VEC[i][7:0]);
      chk("R10 dout_en on read", {7'd0, en}, 8'd1);
    end
    chk("R10 dout_en idle", {7'd0, dout_en}, 8'd0);

    // R5 full page load, gaps inside the window
    for (int i = 0; i < 64; i++) begin
      wr_byte(AW'(192 + i), fillv(i));
      if (i == 31 || i == 63) chk("R5 busy low while loading", {7'd0, busy}, 8'd0);
    end
    wait_prog();
    rd_byte(AW'(192), d, en);      chk("R4 page byte 0", d, fillv(0));
    rd_byte(AW'(192 + 31), d, en); chk("R4 page byte 31", d, fillv(31));
    rd_byte(AW'(192 + 63), d, en); chk("R4 page byte 63", d, fillv(63));

    // R13 partial rewrite keeps neighbours
    wr_byte(AW'(192 + 5), 8'hD5);
    wr_byte(AW'(192 + 60), 8'hE6);
    wait_prog();
    rd_byte(AW'(192 + 5), d, en);  chk("R13 rewritten 5", d, 8'hD5);
    rd_byte(AW'(192 + 60), d, en); chk("R13 rewritten 60", d, 8'hE6);
    rd_byte(AW'(192 + 6), d, en);  chk("R13 untouched 6", d, fillv(6));
    rd_byte(AW'(192 + 59), d, en); chk("R13 untouched 59", d, fillv(59));

    // R6 / R7 exact timing
    wr_byte(AW'(10 * 64 + 42), 8'h77);
    repeat (GAP - 2) @(negedge clk);
    chk("R6 busy before window end", {7'd0, busy}, 8'd0);
    @(negedge clk);
    chk("R6 busy at window end", {7'd0, busy}, 8'd1);
    repeat (PCYC - 1) @(negedge clk);
    chk("R7 busy last cycle", {7'd0, busy}, 8'd1);
    @(negedge clk);
    chk("R7 busy released", {7'd0, busy}, 8'd0);

    // R8 / R9 status polling
    wr_byte(AW'(192 + 30), 8'h3C);
    while (!busy) @(negedge clk);
    rd_byte(AW'(192 + 30), r1, en);
    chk("R8 status en", {7'd0, en}, 8'd1);
    rd_byte(AW'(192 + 30), r2, en);
    chk("R8 bit7 inverted", {7'd0, r1[7]}, 8'd1);
    chk("R8 low bits", {2'd0, r1[5:0]}, 8'h3C);
    chk("R8 bit7 second read", {7'd0, r2[7]}, 8'd1);
    chk("R9 bit6 toggles", {7'd0, r2[6]}, {7'd0, ~r1[6]});
    while (busy) @(negedge clk);
    rd_byte(AW'(192 + 30), d, en);
    chk("R9 true data after prog", d, 8'h3C);

    // R12 writes during programming ignored
    wr_byte(AW'(192 + 20), 8'h11);
    while (!busy) @(negedge clk);
    wr_byte(AW'(192 + 21), 8'h99);
    while (busy) @(negedge clk);
    repeat (GAP + 10) @(negedge clk);
    chk("R12 no new load", {7'd0, busy}, 8'd0);
    rd_byte(AW'(192 + 20), d, en); chk("R12 pre-prog byte", d, 8'h11);
    rd_byte(AW'(192 + 21), d, en); chk("R12 busy write dropped", d, fillv(21));

    // R11 off-page byte
    wr_byte(AW'(5 * 64 + 1), 8'h21);
    wr_byte(AW'(385), 8'h62);
    @(negedge clk);
    chk("R11 flag set", {7'd0, page_err}, 8'd1);
    wait_prog();
    rd_byte(AW'(321), d, en); chk("R11 first page kept", d, 8'h21);
    rd_byte(AW'(385), d, en); chk("R11 off-page dropped", d, 8'h5A);
    chk("R11 flag held", {7'd0, page_err}, 8'd1);
    wr_byte(AW'(321), 8'h22);
    @(negedge clk);
    chk("R11 flag cleared", {7'd0, page_err}, 8'd0);
    wait_prog();

    // R2 inhibited strobes
    @(negedge clk); addr = AW'(385); din = 8'hEE; sel_n = 1'b0; ren_n = 1'b0; wen_n = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1;
    repeat (2) @(negedge clk);
    wen_n = 1'b0;
    repeat (3) @(negedge clk);
    wen_n = 1'b1;
    repeat (GAP + 10) @(negedge clk);
    chk("R2 no load started", {7'd0, busy}, 8'd0);
    rd_byte(AW'(385), d, en); chk("R2 array unchanged", d, 8'h5A);

    // R3 address at start, data at end
    @(negedge clk); addr = AW'(192 + 10); din = 8'h01; sel_n = 1'b0; wen_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = AW'(192 + 11); din = 8'hB7;
    repeat (2) @(negedge clk);
    sel_n = 1'b1; wen_n = 1'b1;
    @(negedge clk);
    wait_prog();
    rd_byte(AW'(192 + 10), d, en); chk("R3 late data at early addr", d, 8'hB7);
    rd_byte(AW'(192 + 11), d, en); chk("R3 late addr untouched", d, fillv(11));

    summary();
    $finish;
  end
endmodule